// File: doc/BRIEF.md
# Double-Precision Compare With Predicate Select

This unit compares two IEEE-754 binary64 operands and reduces the outcome to one condition bit. The caller supplies a five-bit predicate word. Four of its bits select which relations count as true: unordered, equal, less and greater. The fifth bit asks for quiet NaNs to be treated as invalid. The unit sorts the operands into NaN, infinity, zero and ordinary values. It resolves signed zeros and orders sign-magnitude patterns. It then picks the predicate bit that belongs to the relation it found.

An invalid operation is reported in one of two ways, chosen by a trap-enable input. With the trap on, the unit raises a trap request. With the trap off, it raises a one-cycle pulse that sets a sticky invalid flag held elsewhere. The two are never raised together.

All three outputs are registered. A result appears one clock after its operands and predicate are presented.

Top module: `fpcmp_unit`

## Requirements
- R1: An operand whose exponent field (bits 62..52) is all ones is a NaN when its fraction (bits 51..0) is non-zero. With a zero fraction it is an infinity. Infinities are ordered normally: +inf is greater than every finite value and -inf is less than every finite value.
- R2: An operation is invalid when either operand is a NaN and, for that operand, fraction bit 51 is one (signalling) or predicate bit 0 (quiet-NaN exception request) is one.
- R3: On an invalid operation with trap_en_i=1, the following cycle shows inv_trap_o=1, inv_flag_o=0, and cond_o equal to predicate bit 1 (the unordered select).
- R4: On an invalid operation with trap_en_i=0, the following cycle shows inv_flag_o=1, inv_trap_o=0, and cond_o equal to predicate bit 1.
- R5: When either operand is a NaN and the operation is not invalid, cond_o equals predicate bit 1, and neither inv_flag_o nor inv_trap_o is raised.
- R6: For non-NaN operands of opposite sign, the relation is equal when both have a zero exponent and a zero fraction, so cond_o equals predicate bit 2. Otherwise the relation is less (predicate bit 3) if the left operand is negative, and greater (predicate bit 4) if it is positive.
- R7: For non-NaN operands with identical 64-bit patterns, cond_o equals predicate bit 2.
- R8: For two positive non-NaN operands with different patterns, an unsigned compare of bits 62..0 decides the result. Smaller gives less (predicate bit 3); larger gives greater (predicate bit 4).
- R9: For two negative non-NaN operands with different patterns, the sense of R8 is reversed: the larger magnitude gives less.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge. While rst_n is low at a rising edge, all outputs become 0. inv_flag_o and inv_trap_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opa_i | input | 64 | Left operand, binary64 bit pattern |
| opb_i | input | 64 | Right operand, binary64 bit pattern |
| pred_i | input | 5 | Predicate: bit0 quiet-NaN exception, bit1 unordered, bit2 equal, bit3 less, bit4 greater |
| trap_en_i | input | 1 | 1 selects trap reporting, 0 selects flag reporting |
| cond_o | output | 1 | Selected condition bit |
| inv_flag_o | output | 1 | One-cycle strobe to set the invalid flag |
| inv_trap_o | output | 1 | One-cycle invalid trap request |

## Verification
The assertions take for granted that every input carries a known value at each rising edge. They also assume the inputs of one edge belong together as a single compare, since the checks relate registered outputs to the previous cycle's operands and predicate through $past. The stimulus meets both conditions. It drives defined values from time zero, including during reset, and changes inputs only on the falling edge. The sweep crosses sixteen operand patterns (signed zeros, subnormals, neighbours differing only in the low word, extremes, infinities, and quiet and signalling NaNs of both signs) with every predicate word and both trap modes.

// File: rtl/fpcmp_pkg.sv
// Package: shared relation type and predicate bit positions for the
// double-precision compare unit.
// Assumes: predicate word layout is fixed at five bits.
package fpcmp_pkg;

    // Relation found between the two operands.
    typedef enum logic [1:0] {
        REL_UN = 2'd0,
        REL_EQ = 2'd1,
        REL_LT = 2'd2,
        REL_GT = 2'd3
    } rel_e;

    localparam int PRED_W   = 5;
    localparam int PRED_EXC = 0;   // quiet NaN raises invalid
    localparam int PRED_UN  = 1;   // unordered select
    localparam int PRED_EQ  = 2;   // equal select
    localparam int PRED_LT  = 3;   // less-than select
    localparam int PRED_GT  = 4;   // greater-than select

endpackage

// File: rtl/fpcmp_classify.sv
// Module: fpcmp_classify
// Splits one floating-point pattern into sign, magnitude and class flags.
// Assumes: the signalling marker is the top fraction bit, set for a
// signalling NaN.
module fpcmp_classify #(
    parameter  int EXP_W  = 11,
    parameter  int FRAC_W = 52,
    localparam int WIDTH  = 1 + EXP_W + FRAC_W
) (
    input  logic [WIDTH-1:0] op_i,
    output logic             sign_o,
    output logic [WIDTH-2:0] mag_o,
    output logic             nan_o,
    output logic             snan_o,
    output logic             zero_o
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    // Field extraction.
    assign exp_f  = op_i[WIDTH-2 -: EXP_W];
    assign frac_f = op_i[FRAC_W-1:0];

    // Class decode from the fields.
    always_comb begin
        sign_o = op_i[WIDTH-1];
        mag_o  = op_i[WIDTH-2:0];
        nan_o  = (&exp_f) && (|frac_f);
        snan_o = nan_o && frac_f[FRAC_W-1];
        zero_o = ~|op_i[WIDTH-2:0];
    end

endmodule

// File: rtl/fpcmp_order.sv
// Module: fpcmp_order
// Orders two non-NaN sign-magnitude operands (infinities included).
// Assumes: NaN handling is done downstream; the result is meaningless
// when either operand is a NaN.
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  logic             sign_a_i,
    input  logic             sign_b_i,
    input  logic             zero_a_i,
    input  logic             zero_b_i,
    input  logic [MAG_W-1:0] mag_a_i,
    input  logic [MAG_W-1:0] mag_b_i,
    output rel_e             rel_o
);

    logic mag_lt;
    logic mag_eq;

    // Unsigned magnitude compare shared by both sign cases.
    assign mag_lt = mag_a_i < mag_b_i;
    assign mag_eq = mag_a_i == mag_b_i;

    // Relation selection by sign combination.
    always_comb begin
        if (sign_a_i != sign_b_i) begin
            if (zero_a_i && zero_b_i) rel_o = REL_EQ;
            else if (sign_a_i)        rel_o = REL_LT;
            else                      rel_o = REL_GT;
        end else if (mag_eq) begin
            rel_o = REL_EQ;
        end else if (!sign_a_i) begin
            rel_o = mag_lt ? REL_LT : REL_GT;
        end else begin
            rel_o = mag_lt ? REL_GT : REL_LT;
        end
    end

endmodule

// File: rtl/fpcmp_decide.sv
// Module: fpcmp_decide
// Applies NaN and invalid rules, then picks the predicate bit of the
// relation found.
// Assumes: rel_i is valid whenever neither operand is a NaN.
module fpcmp_decide
    import fpcmp_pkg::*;
(
    input  logic [1:0]        nan_i,
    input  logic [1:0]        snan_i,
    input  rel_e              rel_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic              trap_en_i,
    output logic              cond_o,
    output logic              flag_o,
    output logic              trap_o
);

    logic [1:0] op_inv;
    logic       invalid;

    // Invalid test per operand.
    for (genvar k = 0; k < 2; k++) begin : g_inv
        assign op_inv[k] = nan_i[k] && (snan_i[k] || pred_i[PRED_EXC]);
    end
    assign invalid = |op_inv;

    // Output selection: invalid, then quiet unordered, then ordered.
    always_comb begin
        flag_o = 1'b0;
        trap_o = 1'b0;
        if (invalid) begin
            cond_o = pred_i[PRED_UN];
            trap_o = trap_en_i;
            flag_o = !trap_en_i;
        end else if (|nan_i) begin
            cond_o = pred_i[PRED_UN];
        end else begin
            unique case (rel_i)
                REL_EQ:  cond_o = pred_i[PRED_EQ];
                REL_LT:  cond_o = pred_i[PRED_LT];
                REL_GT:  cond_o = pred_i[PRED_GT];
                default: cond_o = pred_i[PRED_UN];
            endcase
        end
    end

endmodule

// File: rtl/fpcmp_unit.sv
// Module: fpcmp_unit (top)
// Double-precision compare with predicate select and invalid reporting.
// One register stage: results appear one clock after the inputs.
// Assumes: inputs are known at each rising edge; rst_n is synchronous.
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter  int EXP_W  = 11,
    parameter  int FRAC_W = 52,
    localparam int WIDTH  = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  opa_i,
    input  logic [WIDTH-1:0]  opb_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic              trap_en_i,
    output logic              cond_o,
    output logic              inv_flag_o,
    output logic              inv_trap_o
);

    localparam int MAG_W = WIDTH - 1;

    logic [WIDTH-1:0] op_v   [2];
    logic [MAG_W-1:0] mag_v  [2];
    logic [1:0]       sign_v;
    logic [1:0]       nan_v;
    logic [1:0]       snan_v;
    logic [1:0]       zero_v;
    rel_e             rel_c;
    logic             cond_c;
    logic             flag_c;
    logic             trap_c;

    assign op_v[0] = opa_i;
    assign op_v[1] = opb_i;

    // One classifier per operand.
    for (genvar i = 0; i < 2; i++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op_i   (op_v[i]),
            .sign_o (sign_v[i]),
            .mag_o  (mag_v[i]),
            .nan_o  (nan_v[i]),
            .snan_o (snan_v[i]),
            .zero_o (zero_v[i])
        );
    end

    fpcmp_order #(.MAG_W(MAG_W)) u_order (
        .sign_a_i (sign_v[0]),
        .sign_b_i (sign_v[1]),
        .zero_a_i (zero_v[0]),
        .zero_b_i (zero_v[1]),
        .mag_a_i  (mag_v[0]),
        .mag_b_i  (mag_v[1]),
        .rel_o    (rel_c)
    );

    fpcmp_decide u_decide (
        .nan_i     (nan_v),
        .snan_i    (snan_v),
        .rel_i     (rel_c),
        .pred_i    (pred_i),
        .trap_en_i (trap_en_i),
        .cond_o    (cond_c),
        .flag_o    (flag_c),
        .trap_o    (trap_c)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_o     <= 1'b0;
            inv_flag_o <= 1'b0;
            inv_trap_o <= 1'b0;
        end else begin
            cond_o     <= cond_c;
            inv_flag_o <= flag_c;
            inv_trap_o <= trap_c;
        end
    end

    // Checker view of an invalid operation, built from classifier outputs.
    logic chk_inv;
    assign chk_inv = (nan_v[0] && (snan_v[0] || pred_i[PRED_EXC])) ||
                     (nan_v[1] && (snan_v[1] || pred_i[PRED_EXC]));

    assert_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_inv && trap_en_i) |=>
        (inv_trap_o && !inv_flag_o && cond_o == $past(pred_i[PRED_UN])));

    assert_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_inv && !trap_en_i) |=>
        (inv_flag_o && !inv_trap_o && cond_o == $past(pred_i[PRED_UN])));

    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|nan_v) && !chk_inv) |=>
        (!inv_flag_o && !inv_trap_o && cond_o == $past(pred_i[PRED_UN])));

    assert_zeros_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((&zero_v) && !(|nan_v)) |=> (cond_o == $past(pred_i[PRED_EQ])));

    assert_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((opa_i == opb_i) && !(|nan_v)) |=> (cond_o == $past(pred_i[PRED_EQ])));

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_flag_o && inv_trap_o));

endmodule

// File: tb/sim_fpcmp_unit.sv
// Bench: sweeps sixteen operand patterns in both positions, every
// predicate word and both trap modes. Expected relations come from the
// real-number value of each pattern.
module sim_fpcmp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = 64'd0;
    logic [63:0] opb = 64'd0;
    logic [4:0]  pred = 5'd0;
    logic        trap_en = 1'b0;
    logic        cond, flag, trap;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fpcmp_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .opa_i      (opa),
        .opb_i      (opb),
        .pred_i     (pred),
        .trap_en_i  (trap_en),
        .cond_o     (cond),
        .inv_flag_o (flag),
        .inv_trap_o (trap)
    );

    function automatic logic [63:0] pat(input int k);
        case (k)
            0:  return 64'h0000_0000_0000_0000;   // +0
            1:  return 64'h8000_0000_0000_0000;   // -0
            2:  return 64'h0000_0000_0000_0001;   // +min subnormal
            3:  return 64'h8000_0000_0000_0001;
            4:  return 64'h3FF0_0000_0000_0000;   // +1
            5:  return 64'hBFF0_0000_0000_0000;
            6:  return 64'h3FF0_0000_0000_0001;   // +1 + ulp
            7:  return 64'hBFF0_0000_0000_0001;
            8:  return 64'h7FEF_FFFF_FFFF_FFFF;   // +max
            9:  return 64'hFFEF_FFFF_FFFF_FFFF;
            10: return 64'h7FF0_0000_0000_0000;   // +inf
            11: return 64'hFFF0_0000_0000_0000;   // -inf
            12: return 64'h7FF0_0000_0000_0001;   // quiet NaN (bit51=0)
            13: return 64'h7FF8_0000_0000_0000;   // signalling NaN (bit51=1)
            14: return 64'hFFF4_0000_0000_0000;   // negative quiet NaN
            default: return 64'hFFFF_FFFF_FFFF_FFFF; // negative signalling NaN
        endcase
    endfunction

    function automatic bit is_nan(input logic [63:0] x);
        return (&x[62:52]) && (|x[51:0]);
    endfunction

    task automatic check(input logic [2:0] got, input logic [2:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h pred=%b trap_en=%b {cond,flag,trap} got %b expected %b",
                     tag, opa, opb, pred, trap_en, got, exp);
        end
    endtask

    initial begin
        // R10: reset state, with inputs that would otherwise trap.
        opa = pat(13); opb = pat(4); pred = 5'b11111; trap_en = 1'b1;
        repeat (3) @(negedge clk);
        check({cond, flag, trap}, 3'b000, "R10 reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int p = 0; p < 32; p++) begin
                    for (int t = 0; t < 2; t++) begin
                        logic [2:0] e;
                        string      tag;
                        bit         na, nb, inv;
                        real        ra, rb;
                        opa = pat(a); opb = pat(b); pred = p[4:0]; trap_en = t[0];
                        na  = is_nan(opa);
                        nb  = is_nan(opb);
                        inv = (na && (opa[51] || pred[0])) || (nb && (opb[51] || pred[0]));
                        if (inv) begin
                            e   = {pred[1], !trap_en, trap_en};
                            tag = trap_en ? "R2 R3" : "R2 R4";
                        end else if (na || nb) begin
                            e   = {pred[1], 2'b00};
                            tag = "R5";
                        end else begin
                            ra = $bitstoreal(opa);
                            rb = $bitstoreal(opb);
                            if (ra == rb)     e = {pred[2], 2'b00};
                            else if (ra < rb) e = {pred[3], 2'b00};
                            else              e = {pred[4], 2'b00};
                            if ((&opa[62:52]) || (&opb[62:52])) tag = "R1";
                            else if (opa[63] != opb[63])        tag = "R6";
                            else if (opa == opb)                tag = "R7";
                            else if (!opa[63])                  tag = "R8";
                            else                                tag = "R9";
                        end
                        @(negedge clk);
                        check({cond, flag, trap}, e, tag);
                        if (flag && trap) check(3'b110, 3'b000, "R10 exclusive");
                    end
                end
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule